// File: doc/BRIEF.md
# Timer-Driven Masked Step Sequencer

This block runs a fixed cycle of output patterns and holds each one for its own dwell time. A single position register selects two constant tables at once. One table gives a 16-bit pattern and the other gives a dwell preset counted in seconds. On every advance the new pattern is merged into the 16-bit output word through the fixed mask `0x0077`. Bits outside the mask keep whatever they held before. A typical use is a traffic-light controller in which the green and amber phases have different lengths.

An internal on-delay timer counts one-second clock-enable ticks while `run_en` is high. When the count reaches the preset of the current position, the timer expires. On that clock edge the position advances, the timer restarts from zero and `step_done` goes high for one clock.

The control state machine has two named states:
- `ST_START` is position 0. It applies an all-zero pattern and lasts one tick.
- `ST_STEP` covers positions 1 to 4.

It has three named transitions:
- `ADV_FIRST` goes from `ST_START` to `ST_STEP` at position 1.
- `ADV_NEXT` goes from position p to p+1 within `ST_STEP`.
- `ADV_WRAP` goes from position 4 back to position 1, staying in `ST_STEP`.

Synchronous reset returns the machine to `ST_START`.

Top module: `masked_dwell_sequencer`

## Requirements
- R1: While `rst` is high at a clock edge, the following values are set:
  - `step_pos` becomes 0 and `step_done` becomes 0.
  - `out_word` becomes parameter `RESET_WORD` with bits 0-2 and 4-6 cleared. The default `RESET_WORD` is 0.
  - The tick accumulator clears to 0.
- R2: The mask is 0x0077. Bits 3 and 7-15 of `out_word` never change after reset. Bits 0-2 and 4-6 change only on an advance.
- R3: Position 0 (`ST_START`) has a zero preset and is left on the first counted tick. It moves to position 1.
- R4: On the edge that enters each position, the masked bits of `out_word` take that position's pattern:

  | Position | Pattern |
  |---|---|
  | 1 | 0x0021 |
  | 2 | 0x0011 |
  | 3 | 0x0014 |
  | 4 | 0x0012 |
- R5: Each position lasts a fixed number of counted ticks from entry to advance:

  | Position | Counted ticks |
  |---|---|
  | 1 | 25 |
  | 2 | 5 |
  | 3 | 25 |
  | 4 | 5 |
- R6: The advance out of position 4 goes to position 1, never to 0. The cycle repeats without end.
- R7: `step_done` is high for exactly the one clock after each advance edge, alongside the new `step_pos`. It is low otherwise.
- R8: While `run_en` is low, `sec_tick` is ignored. Position, accumulator and `out_word` all hold. The count resumes from where it stopped once `run_en` returns high.
- R9: A reset in the middle of a step discards the partial count. After the start tick, position 1 again needs its full 25 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sec_tick | input | 1 | One-clock pulse marking one second |
| run_en | input | 1 | Counting enable; low freezes the sequence |
| out_word | output | 16 | Masked output word |
| step_pos | output | 3 | Current position, 0 = start, 1..4 = steps |
| step_done | output | 1 | One-clock pulse after each advance |

## Verification
The bench presets the unmasked bits through `RESET_WORD` and runs two full cycles, counting ticks per position. This catches several faults:
- A mask error would disturb bits 3 or 7-15.
- A table slip would show a wrong pattern or a wrong 25/5/25/5 count.
- A wrap to 0 would add an extra one-tick start step.

The bench also freezes `run_en` partway through a step. A design that counted ticks while disabled, or that cleared the count on the freeze, would leave after other than the remaining 15 ticks. A reset in the middle of a step checks that a stale accumulator does not shorten the first step that follows.

// File: rtl/seq_pkg.sv
package seq_pkg;

    localparam int SEQ_WORD_W = 16;
    localparam int SEQ_STEPS  = 4;
    localparam int SEQ_POS_W  = $clog2(SEQ_STEPS + 1);
    localparam int SEQ_ACC_W  = 8;

    typedef enum logic [0:0] {
        ST_START = 1'b0,
        ST_STEP  = 1'b1
    } seq_state_e;

    // Output pattern for each position (0 is the start entry).
    function automatic logic [SEQ_WORD_W-1:0] pattern_of(input logic [SEQ_POS_W-1:0] idx);
        logic [SEQ_WORD_W-1:0] p;
        case (idx)
            3'd1:    p = 16'h0021;
            3'd2:    p = 16'h0011;
            3'd3:    p = 16'h0014;
            3'd4:    p = 16'h0012;
            default: p = 16'h0000;
        endcase
        return p;
    endfunction

    // Dwell preset, in ticks, for each position.
    function automatic logic [SEQ_ACC_W-1:0] preset_of(input logic [SEQ_POS_W-1:0] idx);
        logic [SEQ_ACC_W-1:0] d;
        case (idx)
            3'd1:    d = 8'd25;
            3'd2:    d = 8'd5;
            3'd3:    d = 8'd25;
            3'd4:    d = 8'd5;
            default: d = 8'd0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/dwell_timer.sv
module dwell_timer #(
    parameter int ACC_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             en,
    input  logic [ACC_W-1:0] preset,
    output logic             expire
);
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W:0]   acc_inc;
    logic [ACC_W:0]   limit;
    logic             counting;

    assign counting = tick & en;
    assign acc_inc  = {1'b0, acc_q} + {{ACC_W{1'b0}}, 1'b1};
    // A zero preset still needs one counted tick.
    assign limit    = (preset == '0) ? {{ACC_W{1'b0}}, 1'b1} : {1'b0, preset};
    assign expire   = counting && (acc_inc >= limit);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (expire) begin
            acc_q <= '0;
        end else if (counting) begin
            acc_q <= acc_inc[ACC_W-1:0];
        end
    end
endmodule

// File: rtl/masked_word_reg.sv
module masked_word_reg #(
    parameter int          WORD_W     = 16,
    parameter logic [15:0] MASK       = 16'h0077,
    parameter logic [15:0] RESET_WORD = 16'h0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] pattern,
    output logic [WORD_W-1:0] word
);
    localparam logic [WORD_W-1:0] M    = MASK[WORD_W-1:0];
    localparam logic [WORD_W-1:0] INIT = RESET_WORD[WORD_W-1:0] & ~M;

    always_ff @(posedge clk) begin
        if (rst) begin
            word <= INIT;
        end else if (load) begin
            word <= (word & ~M) | (pattern & M);
        end
    end
endmodule

// File: rtl/masked_dwell_sequencer.sv
module masked_dwell_sequencer
    import seq_pkg::*;
#(
    parameter logic [15:0] MASK       = 16'h0077,
    parameter logic [15:0] RESET_WORD = 16'h0000
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  sec_tick,
    input  logic                  run_en,
    output logic [SEQ_WORD_W-1:0] out_word,
    output logic [SEQ_POS_W-1:0]  step_pos,
    output logic                  step_done
);
    localparam logic [SEQ_POS_W-1:0] POS_FIRST = SEQ_POS_W'(1);
    localparam logic [SEQ_POS_W-1:0] POS_LAST  = SEQ_POS_W'(SEQ_STEPS);

    seq_state_e           st_q, st_n;
    logic [SEQ_POS_W-1:0] pos_q, pos_n;
    logic                 expire;
    logic [SEQ_ACC_W-1:0] cur_preset;
    logic [SEQ_WORD_W-1:0] next_pattern;
    logic                 done_q;

    assign cur_preset   = preset_of(pos_q);
    assign next_pattern = pattern_of(pos_n);

    dwell_timer #(
        .ACC_W (SEQ_ACC_W)
    ) u_timer (
        .clk    (clk),
        .rst    (rst),
        .tick   (sec_tick),
        .en     (run_en),
        .preset (cur_preset),
        .expire (expire)
    );

    // Next-state: ADV_FIRST, ADV_NEXT, ADV_WRAP
    always_comb begin
        st_n  = st_q;
        pos_n = pos_q;
        if (expire) begin
            unique case (st_q)
                ST_START: begin
                    st_n  = ST_STEP;
                    pos_n = POS_FIRST;
                end
                ST_STEP: begin
                    pos_n = (pos_q == POS_LAST) ? POS_FIRST : pos_q + SEQ_POS_W'(1);
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_START;
            pos_q  <= '0;
            done_q <= 1'b0;
        end else begin
            st_q   <= st_n;
            pos_q  <= pos_n;
            done_q <= expire;
        end
    end

    masked_word_reg #(
        .WORD_W     (SEQ_WORD_W),
        .MASK       (MASK),
        .RESET_WORD (RESET_WORD)
    ) u_word (
        .clk     (clk),
        .rst     (rst),
        .load    (expire),
        .pattern (next_pattern),
        .word    (out_word)
    );

    // Outputs
    always_comb begin
        step_pos  = pos_q;
        step_done = done_q;
    end
endmodule

// File: rtl/masked_dwell_sequencer_chk.sv
module masked_dwell_sequencer_chk
    import seq_pkg::*;
#(
    parameter logic [15:0] MASK = 16'h0077
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  run_en,
    input logic [SEQ_WORD_W-1:0] out_word,
    input logic [SEQ_POS_W-1:0]  step_pos,
    input logic                  step_done
);
    logic armed = 1'b0;
    always_ff @(posedge clk) if (rst) armed <= 1'b1;

    // R2
    unmasked_hold_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        !$past(rst) |-> (out_word & ~MASK) == ($past(out_word) & ~MASK));

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        step_done |=> !step_done);

    // R7
    done_on_move_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        !$past(rst) |-> step_done == (step_pos != $past(step_pos)));

    // R8
    freeze_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        !run_en |=> $stable(step_pos) && $stable(out_word));

    // R6
    no_return_start_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        step_pos != '0 |=> step_pos != '0);

    // R6
    pos_range_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        step_pos <= SEQ_POS_W'(SEQ_STEPS));

    // R4
    pattern_on_entry_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        step_done |-> (out_word & MASK) == (pattern_of(step_pos) & MASK));
endmodule

bind masked_dwell_sequencer masked_dwell_sequencer_chk #(.MASK(MASK)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .run_en    (run_en),
    .out_word  (out_word),
    .step_pos  (step_pos),
    .step_done (step_done)
);

// File: tb/tb_masked_dwell_sequencer.sv
`timescale 1ns/1ps
module tb_masked_dwell_sequencer;
    localparam logic [15:0] MASK_C  = 16'h0077;
    localparam logic [15:0] RST_W   = 16'hFF8F;
    localparam logic [15:0] KEEP    = RST_W & ~MASK_C;   // 16'hFF88

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sec_tick = 1'b0;
    logic        run_en = 1'b1;
    logic [15:0] out_word;
    logic [2:0]  step_pos;
    logic        step_done;

    int vectors = 0;
    int miscomp = 0;

    logic [15:0] exp_pat [0:4];
    int          exp_len [0:4];

    always #5 clk = ~clk;

    masked_dwell_sequencer #(.MASK(MASK_C), .RESET_WORD(RST_W)) dut (
        .clk(clk), .rst(rst), .sec_tick(sec_tick), .run_en(run_en),
        .out_word(out_word), .step_pos(step_pos), .step_done(step_done)
    );

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        vectors++;
        if (!ok) begin
            miscomp++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // One tick; returns at the negedge after the capturing edge.
    task automatic pulse();
        @(negedge clk) sec_tick = 1'b1;
        @(negedge clk) sec_tick = 1'b0;
    endtask

    task automatic gap();
        repeat (3) @(negedge clk);
    endtask

    // Counts ticks until the position moves; checks entry values.
    task automatic run_step(input int want_ticks, input logic [2:0] want_next);
        logic [2:0] start_pos;
        int n;
        start_pos = step_pos;
        n = 0;
        do begin
            pulse();
            n++;
            if (step_pos == start_pos) begin
                check(step_done == 1'b0, "R7 done idle", step_done, 0);
                gap();
            end
        end while (step_pos == start_pos && n < 100);
        check(n == want_ticks, "R5 dwell ticks", n, want_ticks);
        check(step_pos == want_next, "R6 next position", step_pos, want_next);
        check(step_done == 1'b1, "R7 done pulse", step_done, 1);
        check(out_word == (KEEP | (exp_pat[want_next] & MASK_C)), "R4 pattern",
              out_word, KEEP | (exp_pat[want_next] & MASK_C));
        check((out_word & ~MASK_C) == KEEP, "R2 unmasked hold", out_word & ~MASK_C, KEEP);
        @(negedge clk);
        check(step_done == 1'b0, "R7 done width", step_done, 0);
        gap();
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(out_word == KEEP, "R1 reset word", out_word, KEEP);
        check(step_pos == 3'd0, "R1 reset pos", step_pos, 0);
        check(step_done == 1'b0, "R1 reset done", step_done, 0);
        rst = 1'b0;
        gap();
        check(step_pos == 3'd0, "R1 hold start", step_pos, 0);
    endtask

    task automatic t_start();
        run_step(1, 3'd1);   // R3: start lasts one tick
    endtask

    task automatic t_two_cycles();
        for (int c = 0; c < 2; c++) begin
            run_step(exp_len[1], 3'd2);
            run_step(exp_len[2], 3'd3);
            run_step(exp_len[3], 3'd4);
            run_step(exp_len[4], 3'd1);   // R6 wrap
        end
    endtask

    task automatic t_freeze();
        logic [15:0] w;
        for (int i = 0; i < 10; i++) begin pulse(); gap(); end
        check(step_pos == 3'd1, "R8 pre-freeze pos", step_pos, 1);
        w = out_word;
        run_en = 1'b0;
        for (int i = 0; i < 30; i++) begin
            pulse();
            if (step_pos != 3'd1 || out_word != w || step_done)
                check(1'b0, "R8 frozen", step_pos, 1);
            gap();
        end
        check(step_pos == 3'd1 && out_word == w, "R8 frozen state", out_word, w);
        run_en = 1'b1;
        run_step(15, 3'd2);   // R8 resumes with remaining count
    endtask

    task automatic t_mid_reset();
        for (int i = 0; i < 3; i++) begin pulse(); gap(); end
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check(step_pos == 3'd0 && out_word == KEEP, "R9 reset mid-step", out_word, KEEP);
        rst = 1'b0;
        gap();
        run_step(1, 3'd1);
        run_step(25, 3'd2);   // R9 full dwell after reset
    endtask

    initial begin
        exp_pat[0] = 16'h0000; exp_pat[1] = 16'h0021; exp_pat[2] = 16'h0011;
        exp_pat[3] = 16'h0014; exp_pat[4] = 16'h0012;
        exp_len[0] = 1; exp_len[1] = 25; exp_len[2] = 5; exp_len[3] = 25; exp_len[4] = 5;
        t_reset();
        t_start();
        t_two_cycles();
        t_freeze();
        t_mid_reset();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        miscomp++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
        $finish;
    end
endmodule